// File: doc/BRIEF.md
# Video Timing Reference Decoder

This block sits behind a word aligner in a serial digital video receiver. It watches a stream of 10-bit codes and picks out the timing reference sequences: the reserved preamble 3FF, 000, 000 followed by the word that carries the field, vertical-blanking and horizontal flags. It runs in two layouts. In SD mode one multiplexed 10-bit stream sits on the low half of the input. In HD mode the input carries luma on bits 19:10 and chroma on bits 9:0, and both channels carry the reference together.

Each input word comes back one cycle later together with a set of markers. These say whether the word is a flag word and which kind (end or start of active video), whether it is active picture, whether it ends an ancillary data flag, and, in HD mode, whether it is one of the line-number or CRC words that follow the end-of-active-video reference. A line CRC checker further down the chain uses these markers to pick its words. The field, vertical and horizontal outputs hold the value from the most recent flag word.

Top module: `vid_trs_decoder`

## Requirements
- R1: While reset is low, and after it is released until the first valid word, out_vld, every marker and the f_flag, v_flag and h_flag outputs are 0.
- R2: A word is a flag word when its bit 9 (SD, on bits 9:0) or its luma bit 9 (HD, on bit 19) is 1 and the three valid words before it were 3FF, 000, 000 in that order. trs_det is then high for that word. The same preamble followed by a word with bit 9 = 0 gives no detection.
- R3: On each flag word, f_flag, v_flag and h_flag take bits 8, 7 and 6 of the flag code (luma code in HD). Between flag words they hold their value.
- R4: eav_det marks a flag word with H = 1 and sav_det marks one with H = 0. Each of them implies trs_det.
- R5: In HD mode the preamble must appear on both the luma and the chroma channel. If either channel breaks it, no flag word is reported.
- R6: In HD mode the two valid words after an end-of-active-video flag word raise ln_word, and the next two raise crc_word. In SD mode neither output is ever raised.
- R7: After a start-of-active-video flag word with V = 0, act_pic is high for each valid word until the next flag word, except for words holding a reserved code (000 or 3FF) on the decoded channel (either channel in HD). After a flag word with V = 1, act_pic stays low.
- R8: anc_det is high for the word that completes the sequence 000, 3FF, 3FF on the multiplexed stream (SD) or the luma channel (HD). The same sequence on the HD chroma channel gives no detection.
- R9: A cycle with word_vld low is skipped. Its data does not enter the sequence history, and the matching output cycle has out_vld low and all markers 0.
- R10: out_word and out_vld are the input word and word_vld delayed by one clock cycle. The markers in the same cycle describe that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hd_mode | input | 1 | 1: two 10-bit channels (luma 19:10, chroma 9:0); 0: one stream on 9:0 |
| word_vld | input | 1 | Input word strobe |
| word_in | input | 20 | Aligned input word |
| out_vld | output | 1 | Output word strobe |
| out_word | output | 20 | Input word delayed by one cycle |
| trs_det | output | 1 | Output word is a flag word |
| eav_det | output | 1 | Flag word with H = 1 |
| sav_det | output | 1 | Flag word with H = 0 |
| f_flag | output | 1 | Field bit of the last flag word |
| v_flag | output | 1 | Vertical blanking bit of the last flag word |
| h_flag | output | 1 | Horizontal bit of the last flag word |
| act_pic | output | 1 | Output word is active picture |
| anc_det | output | 1 | Output word completes an ancillary data flag |
| ln_word | output | 1 | Output word is a line-number word (HD) |
| crc_word | output | 1 | Output word is a CRC word (HD) |

## Verification
The SD stream is driven with start and end references carrying different F, V and H combinations. This shows that the flags come from the right bit positions, that EAV and SAV are told apart, and that a start reference with V set keeps the active marker low. A preamble followed by a code with its top bit clear, and an HD preamble broken only on chroma, show that both the flag-word bit and the agreement between channels are required. The ancillary flag is driven on luma and then on chroma alone, and the words after an HD end reference are compared with those after an SD one, which separates line-number and CRC marking from plain blanking. A preamble split by invalid cycles holding reserved data shows that gaps leave the sequence history untouched.

// File: rtl/vtrd_pkg.sv
package vtrd_pkg;

  // Per-word classification carried alongside each output word.
  typedef struct packed {
    logic trs;
    logic eav;
    logic sav;
    logic act;
    logic anc;
    logic ln;
    logic crc;
  } vtrd_mark_t;

  // Timing flags taken from a flag word.
  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } vtrd_flags_t;

endpackage

// File: rtl/vtrd_rst_sync.sv
module vtrd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/vtrd_code_hist.sv
// Keeps, for one 10-bit channel, whether each of the last DEPTH valid
// codes was all-ones or all-zeros. Index 0 is the most recent one.
module vtrd_code_hist #(
  parameter int CODE_W = 10,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [CODE_W-1:0] code,
  output logic              cur_max,
  output logic              cur_zero,
  output logic [DEPTH-1:0]  max_q,
  output logic [DEPTH-1:0]  zero_q
);

  logic [DEPTH-1:0] max_d;
  logic [DEPTH-1:0] zero_d;

  assign cur_max  = &code;
  assign cur_zero = ~|code;

  always_comb begin
    max_d  = max_q;
    zero_d = zero_q;
    if (adv) begin
      max_d  = {max_q[DEPTH-2:0], cur_max};
      zero_d = {zero_q[DEPTH-2:0], cur_zero};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q  <= '0;
      zero_q <= '0;
    end else begin
      max_q  <= max_d;
      zero_q <= zero_d;
    end
  end

endmodule

// File: rtl/vtrd_trs_decode.sv
// Combinational match of preamble, flag word and ancillary flag on the
// current word, given per-lane history. Lane 0 = bits 9:0, lane 1 = 19:10.
module vtrd_trs_decode
  import vtrd_pkg::*;
#(
  parameter int LANES = 2,
  parameter int HIST  = 3
) (
  input  logic                  hd_mode,
  input  logic [3:0]            xyz_top,
  input  logic [LANES-1:0]      cur_max,
  input  logic [LANES-1:0]      cur_zero,
  input  logic [LANES*HIST-1:0] max_q,
  input  logic [LANES*HIST-1:0] zero_q,
  output logic                  xyz_hit,
  output vtrd_flags_t           flags,
  output logic                  anc_hit,
  output logic                  reserved
);

  localparam int SD_LANE = 0;
  localparam int HD_LANE = LANES - 1;

  logic [LANES-1:0] lane_pre;
  logic [LANES-1:0] lane_anc;
  logic [LANES-1:0] lane_rsv;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      // oldest 3FF, then 000, then 000 just before the current word
      assign lane_pre[l] = max_q[l*HIST+2] & zero_q[l*HIST+1] & zero_q[l*HIST+0];
      // 000, 3FF, then the current 3FF
      assign lane_anc[l] = zero_q[l*HIST+1] & max_q[l*HIST+0] & cur_max[l];
      assign lane_rsv[l] = cur_max[l] | cur_zero[l];
    end
  endgenerate

  always_comb begin
    flags.f = xyz_top[2];
    flags.v = xyz_top[1];
    flags.h = xyz_top[0];
    if (hd_mode) begin
      xyz_hit  = (&lane_pre) & xyz_top[3];
      anc_hit  = lane_anc[HD_LANE];
      reserved = |lane_rsv;
    end else begin
      xyz_hit  = lane_pre[SD_LANE] & xyz_top[3];
      anc_hit  = lane_anc[SD_LANE];
      reserved = lane_rsv[SD_LANE];
    end
  end

endmodule

// File: rtl/vtrd_line_track.sv
// Tracks the active-picture window and the words that trail an EAV.
module vtrd_line_track #(
  parameter int LN_WORDS  = 2,
  parameter int CRC_WORDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic hd_mode,
  input  logic xyz_hit,
  input  logic flag_v,
  input  logic flag_h,
  input  logic reserved,
  output logic act_word,
  output logic ln_word,
  output logic crc_word
);

  localparam int SPAN  = LN_WORDS + CRC_WORDS;
  localparam int CNT_W = $clog2(SPAN + 1);
  localparam logic [CNT_W-1:0] SPAN_CNT = CNT_W'(SPAN);
  localparam logic [CNT_W-1:0] CRC_CNT  = CNT_W'(CRC_WORDS);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // cnt_q holds how many trailing words remain, counting the current one
  assign act_word = act_q & ~xyz_hit & ~reserved;
  assign ln_word  = ~xyz_hit & (cnt_q > CRC_CNT);
  assign crc_word = ~xyz_hit & (cnt_q != '0) & (cnt_q <= CRC_CNT);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (adv) begin
      if (xyz_hit) begin
        act_d = ~flag_h & ~flag_v;
        cnt_d = (hd_mode & flag_h) ? SPAN_CNT : '0;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/vid_trs_decoder.sv
module vid_trs_decoder
  import vtrd_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int LN_WORDS  = 2,
  parameter int CRC_WORDS = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hd_mode,
  input  logic                word_vld,
  input  logic [2*CODE_W-1:0] word_in,
  output logic                out_vld,
  output logic [2*CODE_W-1:0] out_word,
  output logic                trs_det,
  output logic                eav_det,
  output logic                sav_det,
  output logic                f_flag,
  output logic                v_flag,
  output logic                h_flag,
  output logic                act_pic,
  output logic                anc_det,
  output logic                ln_word,
  output logic                crc_word
);

  localparam int LANES   = 2;
  localparam int DATA_W  = LANES * CODE_W;
  localparam int TRS_PRE = 3;

  logic rst_n_i;

  vtrd_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  logic [LANES-1:0]         cur_max;
  logic [LANES-1:0]         cur_zero;
  logic [LANES*TRS_PRE-1:0] max_q;
  logic [LANES*TRS_PRE-1:0] zero_q;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_hist
      vtrd_code_hist #(.CODE_W(CODE_W), .DEPTH(TRS_PRE)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n_i),
        .adv      (word_vld),
        .code     (word_in[l*CODE_W +: CODE_W]),
        .cur_max  (cur_max[l]),
        .cur_zero (cur_zero[l]),
        .max_q    (max_q[l*TRS_PRE +: TRS_PRE]),
        .zero_q   (zero_q[l*TRS_PRE +: TRS_PRE])
      );
    end
  endgenerate

  // top four bits of the decoded code: marker bit, F, V, H
  logic [3:0] xyz_top;
  assign xyz_top = hd_mode ? word_in[DATA_W-1 -: 4] : word_in[CODE_W-1 -: 4];

  logic        xyz_hit;
  vtrd_flags_t dec_flags;
  logic        anc_hit;
  logic        reserved;

  vtrd_trs_decode #(.LANES(LANES), .HIST(TRS_PRE)) u_dec (
    .hd_mode  (hd_mode),
    .xyz_top  (xyz_top),
    .cur_max  (cur_max),
    .cur_zero (cur_zero),
    .max_q    (max_q),
    .zero_q   (zero_q),
    .xyz_hit  (xyz_hit),
    .flags    (dec_flags),
    .anc_hit  (anc_hit),
    .reserved (reserved)
  );

  logic act_w, ln_w, crc_w;

  vtrd_line_track #(.LN_WORDS(LN_WORDS), .CRC_WORDS(CRC_WORDS)) u_line (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .adv      (word_vld),
    .hd_mode  (hd_mode),
    .xyz_hit  (xyz_hit),
    .flag_v   (dec_flags.v),
    .flag_h   (dec_flags.h),
    .reserved (reserved),
    .act_word (act_w),
    .ln_word  (ln_w),
    .crc_word (crc_w)
  );

  vtrd_mark_t        marks_q, marks_d;
  vtrd_flags_t       flags_q, flags_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;

  always_comb begin
    marks_d = '0;
    if (word_vld) begin
      marks_d.trs = xyz_hit;
      marks_d.eav = xyz_hit & dec_flags.h;
      marks_d.sav = xyz_hit & ~dec_flags.h;
      marks_d.act = act_w;
      marks_d.anc = anc_hit;
      marks_d.ln  = ln_w;
      marks_d.crc = crc_w;
    end
    flags_d = (word_vld & xyz_hit) ? dec_flags : flags_q;
    word_d  = word_vld ? word_in : word_q;
    vld_d   = word_vld;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      marks_q <= '0;
      flags_q <= '0;
      word_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      marks_q <= marks_d;
      flags_q <= flags_d;
      word_q  <= word_d;
      vld_q   <= vld_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_word = word_q;
  assign trs_det  = marks_q.trs;
  assign eav_det  = marks_q.eav;
  assign sav_det  = marks_q.sav;
  assign act_pic  = marks_q.act;
  assign anc_det  = marks_q.anc;
  assign ln_word  = marks_q.ln;
  assign crc_word = marks_q.crc;
  assign f_flag   = flags_q.f;
  assign v_flag   = flags_q.v;
  assign h_flag   = flags_q.h;

endmodule

// File: rtl/vid_trs_decoder_chk.sv
module vid_trs_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic hd_mode,
  input logic out_vld,
  input logic trs_det,
  input logic eav_det,
  input logic sav_det,
  input logic f_flag,
  input logic v_flag,
  input logic h_flag,
  input logic act_pic,
  input logic anc_det,
  input logic ln_word,
  input logic crc_word
);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> !(trs_det | eav_det | sav_det | act_pic | anc_det | ln_word | crc_word));

  assert_kind_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eav_det, sav_det}));

  assert_kind_implies_trs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eav_det | sav_det) == trs_det);

  assert_eav_has_h_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eav_det |-> h_flag);

  assert_sav_no_h_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sav_det |-> !h_flag);

  assert_flags_move_on_trs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({f_flag, v_flag, h_flag}) |-> trs_det);

  assert_roles_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trs_det, act_pic, ln_word, crc_word}));

  assert_trailer_hd_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ln_word | crc_word) |-> $past(hd_mode));

endmodule

bind vid_trs_decoder vid_trs_decoder_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .hd_mode  (hd_mode),
  .out_vld  (out_vld),
  .trs_det  (trs_det),
  .eav_det  (eav_det),
  .sav_det  (sav_det),
  .f_flag   (f_flag),
  .v_flag   (v_flag),
  .h_flag   (h_flag),
  .act_pic  (act_pic),
  .anc_det  (anc_det),
  .ln_word  (ln_word),
  .crc_word (crc_word)
);

// File: tb/vid_trs_decoder_tb_top.sv
module vid_trs_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hd_mode;
  logic        word_vld;
  logic [19:0] word_in;
  logic        out_vld;
  logic [19:0] out_word;
  logic        trs_det, eav_det, sav_det;
  logic        f_flag, v_flag, h_flag;
  logic        act_pic, anc_det, ln_word, crc_word;

  always #4 clk = ~clk;

  vid_trs_decoder dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hd_mode  (hd_mode),
    .word_vld (word_vld),
    .word_in  (word_in),
    .out_vld  (out_vld),
    .out_word (out_word),
    .trs_det  (trs_det),
    .eav_det  (eav_det),
    .sav_det  (sav_det),
    .f_flag   (f_flag),
    .v_flag   (v_flag),
    .h_flag   (h_flag),
    .act_pic  (act_pic),
    .anc_det  (anc_det),
    .ln_word  (ln_word),
    .crc_word (crc_word)
  );

  // marker bit order: trs eav sav act anc ln crc
  localparam logic [6:0] M_NONE = 7'b0000000;
  localparam logic [6:0] M_TRS  = 7'b1000000;
  localparam logic [6:0] M_EAV  = 7'b0100000;
  localparam logic [6:0] M_SAV  = 7'b0010000;
  localparam logic [6:0] M_ACT  = 7'b0001000;
  localparam logic [6:0] M_ANC  = 7'b0000100;
  localparam logic [6:0] M_LN   = 7'b0000010;
  localparam logic [6:0] M_CRC  = 7'b0000001;

  typedef struct {
    logic [6:0]  m;
    logic [2:0]  fvh;
    logic [19:0] w;
    string       tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [2:0] model_fvh;
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         mon_en = 1'b0;
  bit         gap_chk = 1'b0;

  function automatic logic [6:0] got_marks();
    return {trs_det, eav_det, sav_det, act_pic, anc_det, ln_word, crc_word};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] actv, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, actv, expv);
    end
  endtask

  // driver: present one word, push what the monitor must see next cycle
  task automatic send(input logic hd, input logic [19:0] w,
                      input logic [6:0] m, input string tag);
    exp_t e;
    hd_mode  = hd;
    word_in  = w;
    word_vld = 1'b1;
    if (m[6]) model_fvh = w[8:6];
    if (m[6] && hd) model_fvh = w[18:16];
    e.m = m; e.fvh = model_fvh; e.w = w; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic sd(input logic [9:0] x, input logic [6:0] m, input string tag);
    send(1'b0, {10'h000, x}, m, tag);
  endtask

  task automatic hd(input logic [9:0] y, input logic [9:0] c,
                    input logic [6:0] m, input string tag);
    send(1'b1, {y, c}, m, tag);
  endtask

  task automatic idle(input int n, input logic [19:0] junk);
    word_vld = 1'b0;
    word_in  = junk;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    exp_t e;
    if (mon_en) begin
      if (out_vld) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected output word", {12'h0, out_word}, 32'h0);
        end else begin
          e = exp_q.pop_front();
          check(got_marks() == e.m && {f_flag, v_flag, h_flag} == e.fvh && out_word == e.w,
                e.tag, "marks/fvh/word",
                {2'b00, got_marks(), f_flag, v_flag, h_flag, out_word},
                {2'b00, e.m, e.fvh, e.w});
        end
      end else if (gap_chk) begin
        check(got_marks() == M_NONE, "R9", "markers during gap",
              {25'h0, got_marks()}, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; word_vld = 1'b0; hd_mode = 1'b0; word_in = '0; model_fvh = 3'b000;
    repeat (3) @(negedge clk);
    check({out_vld, got_marks(), f_flag, v_flag, h_flag} == '0, "R1", "state in reset",
          {21'h0, out_vld, got_marks(), f_flag, v_flag, h_flag}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({out_vld, got_marks(), f_flag, v_flag, h_flag} == '0, "R1", "state after release",
          {21'h0, out_vld, got_marks(), f_flag, v_flag, h_flag}, 32'h0);
    mon_en = 1'b1;

    // SD: SAV with V=0, active words, EAV (R2 R3 R4 R7 R10)
    sd(10'h3FF, M_NONE, "R2");
    sd(10'h000, M_NONE, "R2");
    sd(10'h000, M_NONE, "R2");
    sd(10'h200, M_TRS | M_SAV, "R4");
    sd(10'h040, M_ACT, "R7");
    sd(10'h200, M_ACT, "R7");
    sd(10'h3AC, M_ACT, "R7");
    sd(10'h3FF, M_NONE, "R7");
    sd(10'h000, M_NONE, "R7");
    sd(10'h000, M_NONE, "R7");
    sd(10'h274, M_TRS | M_EAV, "R3");
    sd(10'h123, M_NONE, "R6");
    sd(10'h321, M_NONE, "R6");

    // SD: SAV with V=1 gives no active picture, then an ancillary flag (R7 R8)
    sd(10'h3FF, M_NONE, "R2");
    sd(10'h000, M_NONE, "R2");
    sd(10'h000, M_NONE, "R2");
    sd(10'h28C, M_TRS | M_SAV, "R3");
    sd(10'h155, M_NONE, "R7");
    sd(10'h000, M_NONE, "R8");
    sd(10'h3FF, M_NONE, "R8");
    sd(10'h3FF, M_ANC, "R8");
    sd(10'h041, M_NONE, "R8");

    // SD: preamble then a code with bit 9 clear, then F=V=H=1 (R2 R3)
    sd(10'h3FF, M_NONE, "R2");
    sd(10'h000, M_NONE, "R2");
    sd(10'h000, M_NONE, "R2");
    sd(10'h100, M_NONE, "R2");
    sd(10'h3FF, M_NONE, "R2");
    sd(10'h000, M_NONE, "R2");
    sd(10'h000, M_NONE, "R2");
    sd(10'h3C4, M_TRS | M_EAV, "R3");

    // SD: preamble split by invalid cycles holding 3FF (R9)
    sd(10'h3FF, M_NONE, "R9");
    sd(10'h000, M_NONE, "R9");
    gap_chk = 1'b1;
    idle(3, 20'h003FF);
    gap_chk = 1'b0;
    sd(10'h000, M_NONE, "R9");
    sd(10'h274, M_TRS | M_EAV, "R9");

    // HD: EAV, line-number and CRC words (R6)
    hd(10'h3FF, 10'h3FF, M_NONE, "R2");
    hd(10'h000, 10'h000, M_NONE, "R2");
    hd(10'h000, 10'h000, M_NONE, "R2");
    hd(10'h274, 10'h274, M_TRS | M_EAV, "R4");
    hd(10'h204, 10'h204, M_LN, "R6");
    hd(10'h220, 10'h220, M_LN, "R6");
    hd(10'h111, 10'h222, M_CRC, "R6");
    hd(10'h333, 10'h0AA, M_CRC, "R6");
    hd(10'h080, 10'h080, M_NONE, "R6");

    // HD: SAV, active words, ancillary flag on luma then on chroma (R7 R8)
    hd(10'h3FF, 10'h3FF, M_NONE, "R2");
    hd(10'h000, 10'h000, M_NONE, "R2");
    hd(10'h000, 10'h000, M_NONE, "R2");
    hd(10'h200, 10'h200, M_TRS | M_SAV, "R4");
    hd(10'h040, 10'h200, M_ACT, "R7");
    hd(10'h1F0, 10'h2A0, M_ACT, "R7");
    hd(10'h000, 10'h040, M_NONE, "R8");
    hd(10'h3FF, 10'h040, M_NONE, "R8");
    hd(10'h3FF, 10'h040, M_ANC, "R8");
    hd(10'h110, 10'h220, M_ACT, "R7");
    hd(10'h040, 10'h000, M_NONE, "R8");
    hd(10'h040, 10'h3FF, M_NONE, "R8");
    hd(10'h040, 10'h3FF, M_NONE, "R8");

    // HD: preamble broken on chroma only (R5), then a proper EAV
    hd(10'h3FF, 10'h3FF, M_NONE, "R5");
    hd(10'h000, 10'h040, M_NONE, "R5");
    hd(10'h000, 10'h000, M_NONE, "R5");
    hd(10'h274, 10'h274, M_ACT, "R5");
    hd(10'h3FF, 10'h3FF, M_NONE, "R5");
    hd(10'h000, 10'h000, M_NONE, "R5");
    hd(10'h000, 10'h000, M_NONE, "R5");
    hd(10'h274, 10'h274, M_TRS | M_EAV, "R5");
    hd(10'h204, 10'h204, M_LN, "R6");

    idle(4, 20'h00000);
    check(exp_q.size() == 0, "R10", "words still owed", exp_q.size(), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule